// File: doc/BRIEF.md
# Branch Delay-Slot Fetch and Squash Controller

This block sequences the fetch address and decides which in-flight instructions are discarded in a five-stage in-order pipeline made of fetch (IF), decode (ID), operand fetch (OF), execute (EX) and writeback (WB). Fetch runs down sequential addresses until a branch resolves. A branch is marked by the decode logic in the cycle it sits in ID, together with an annul flag. The block carries that mark down the pipe and takes the taken/not-taken outcome and target in the cycle the branch reaches EX.

The instruction fetched directly after a branch is the delay slot and is normally executed on both paths. When the branch is taken, every other younger instruction is turned into a bubble before it can reach EX, and fetch restarts at the target. With the annul flag set, the slot is kept when the branch is taken and squashed when it falls through. A fetch stall freezes the PC and the IF and ID stages. A redirect that arrives during a stall is held and applied on the first unstalled cycle. Instruction memory, register file and ALU are outside the block.

Top module: `branch_slot_ctrl`

## Requirements
- R1: While reset is held, `fetch_pc_o` is `RESET_PC` (zero by default) and every bit of `stage_valid_o` is 0. On the first clock edge after release, the IF bit (bit 0) becomes 1 and the PC stays at zero.
- R2: On each clock edge with no stall and no redirect, once IF holds a valid fetch, the PC advances by `INSTR_BYTES` (4). The valid bits shift one stage toward WB: bit 0 IF, 1 ID, 2 OF, 3 EX, 4 WB.
- R3: A branch that falls through with its annul flag clear raises no kill signal, and the PC keeps advancing sequentially.
- R4: When EX holds a valid branch and `ex_taken_i` is 1, `kill_if_o` is 1 in that cycle, together with the kill of every other younger stage that does not hold the delay slot. With no stall, `fetch_pc_o` equals `ex_target_i` after the next edge.
- R5: On a taken branch the delay-slot instruction is not killed, and it reaches EX valid.
- R6: A branch with its annul flag set that falls through kills its delay slot, in OF or ID, during the resolve cycle.
- R7: A branch with its annul flag set that is taken keeps its delay slot and kills the other younger instructions.
- R8: While `fetch_stall_i` is 1, the PC and the IF and ID stages hold, OF receives a bubble, and EX and WB keep advancing.
- R9: A taken branch resolved during a stall kills the younger non-slot instructions at once. The PC holds while the stall lasts and loads the target on the first edge without stall.
- R10: `ex_taken_i` and `ex_target_i` have no effect when EX does not hold a valid branch.
- R11: A killed instruction moves on as a bubble: the next stage's valid bit is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fetch_stall_i | input | 1 | Freeze PC, IF and ID this cycle |
| id_branch_i | input | 1 | Instruction in ID is a branch |
| id_annul_i | input | 1 | Annul flag of the branch in ID |
| ex_taken_i | input | 1 | Outcome of the branch in EX (1 = taken) |
| ex_target_i | input | ADDR_W | Target of the branch in EX |
| fetch_pc_o | output | ADDR_W | Address being fetched this cycle |
| kill_if_o | output | 1 | Discard the instruction in IF |
| kill_id_o | output | 1 | Discard the instruction in ID |
| kill_of_o | output | 1 | Discard the instruction in OF |
| stage_valid_o | output | 5 | Valid bits, bit 0 IF up to bit 4 WB |

## Verification
The kill outputs are combinational: they belong to the same cycle in which the outcome is driven. The bench therefore samples them one time step after driving the inputs at the falling edge. The PC and the stage valid bits are registered, so the new target and the bubbles show up one edge after the resolve cycle and shift by one stage per edge after that. Each directed task counts edges from reset release: the branch is flagged in ID at edge 3 and resolves between edges 5 and 6. Each result is compared exactly at the edge where the requirement places it, including the extra edges a stall holds the redirect back.

// File: rtl/branch_slot_pkg.sv
package branch_slot_pkg;

    localparam int NUM_STAGES = 5;
    localparam int STG_IF = 0;
    localparam int STG_ID = 1;
    localparam int STG_OF = 2;
    localparam int STG_EX = 3;
    localparam int STG_WB = 4;

    // tag carried by an instruction while it is still killable or resolving
    typedef struct packed {
        logic v;     // holds a real instruction
        logic br;    // is a branch
        logic an;    // branch annul flag
        logic slot;  // is the delay slot of the branch ahead of it
    } stage_tag_t;

    typedef struct packed {
        logic       if_v;
        stage_tag_t id;
        stage_tag_t of;
        stage_tag_t ex;
        logic       wb_v;
    } track_state_t;

endpackage

// File: rtl/bsc_pc_seq.sv
module bsc_pc_seq #(
    parameter int                ADDR_W      = 32,
    parameter int                INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stall_i,
    input  logic              fetch_live_i,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] pc_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              pend_v;
        logic [ADDR_W-1:0] pend_pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (redirect_i) begin
            if (stall_i) begin
                // keep the target until fetch may move again
                st_d.pend_v  = 1'b1;
                st_d.pend_pc = target_i;
            end else begin
                st_d.pc     = target_i;
                st_d.pend_v = 1'b0;
            end
        end else if (!stall_i) begin
            if (st_q.pend_v) begin
                st_d.pc     = st_q.pend_pc;
                st_d.pend_v = 1'b0;
            end else if (fetch_live_i) begin
                st_d.pc = st_q.pc + STEP;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pc      <= RESET_PC;
            st_q.pend_v  <= 1'b0;
            st_q.pend_pc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

    assert_redirect_loads_pc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redirect_i && !stall_i) |=> (pc_o == $past(target_i)));

    assert_stall_holds_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_i |=> (pc_o == $past(pc_o)));

    assert_pending_applied_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pend_v && !stall_i && !redirect_i) |=> (pc_o == $past(st_q.pend_pc)));

endmodule

// File: rtl/bsc_stage_track.sv
module bsc_stage_track
    import branch_slot_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  stall_i,
    input  logic                  id_branch_i,
    input  logic                  id_annul_i,
    input  logic                  kill_if_i,
    input  logic                  kill_id_i,
    input  logic                  kill_of_i,
    output stage_tag_t            id_o,
    output stage_tag_t            of_o,
    output stage_tag_t            ex_o,
    output logic                  if_v_o,
    output logic [NUM_STAGES-1:0] stage_valid_o
);

    track_state_t st_d, st_q;
    logic         id_is_branch;

    assign id_is_branch = st_q.id.v && id_branch_i;

    always_comb begin
        st_d = st_q;

        // back end always advances; a killed OF entry becomes a bubble
        st_d.wb_v    = st_q.ex.v;
        st_d.ex.v    = st_q.of.v && !kill_of_i;
        st_d.ex.br   = st_q.of.br;
        st_d.ex.an   = st_q.of.an;
        st_d.ex.slot = st_q.of.slot;

        if (stall_i) begin
            // front end frozen, kills still take effect in place
            st_d.of      = '0;
            st_d.id.v    = st_q.id.v && !kill_id_i;
            st_d.if_v    = st_q.if_v && !kill_if_i;
        end else begin
            st_d.of.v    = st_q.id.v && !kill_id_i;
            st_d.of.br   = id_is_branch;
            st_d.of.an   = id_is_branch && id_annul_i;
            st_d.of.slot = st_q.id.slot;
            st_d.id.v    = st_q.if_v && !kill_if_i;
            st_d.id.br   = 1'b0;
            st_d.id.an   = 1'b0;
            // the fetch following a branch leaving ID is its delay slot
            st_d.id.slot = id_is_branch;
            st_d.if_v    = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign id_o   = st_q.id;
    assign of_o   = st_q.of;
    assign ex_o   = st_q.ex;
    assign if_v_o = st_q.if_v;

    assign stage_valid_o[STG_IF] = st_q.if_v;
    assign stage_valid_o[STG_ID] = st_q.id.v;
    assign stage_valid_o[STG_OF] = st_q.of.v;
    assign stage_valid_o[STG_EX] = st_q.ex.v;
    assign stage_valid_o[STG_WB] = st_q.wb_v;

    assert_killed_of_bubbles_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kill_of_i |=> !st_q.ex.v);

    assert_killed_if_bubbles_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kill_if_i && !stall_i) |=> !st_q.id.v);

    assert_stall_bubbles_of_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_i |=> !st_q.of.v);

endmodule

// File: rtl/bsc_squash.sv
module bsc_squash
    import branch_slot_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  stage_tag_t ex_i,
    input  stage_tag_t of_i,
    input  stage_tag_t id_i,
    input  logic       if_v_i,
    input  logic       taken_i,
    output logic       redirect_o,
    output logic       kill_if_o,
    output logic       kill_id_o,
    output logic       kill_of_o
);

    logic resolve;
    logic go_taken;
    logic drop_slot;

    assign resolve   = ex_i.v && ex_i.br;
    assign go_taken  = resolve && taken_i;
    assign drop_slot = resolve && !taken_i && ex_i.an;

    always_comb begin
        redirect_o = go_taken;
        kill_if_o  = go_taken && if_v_i;
        kill_id_o  = id_i.v && ((go_taken && !id_i.slot) || (drop_slot && id_i.slot));
        kill_of_o  = of_i.v && ((go_taken && !of_i.slot) || (drop_slot && of_i.slot));
    end

    assert_fallthrough_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resolve && !taken_i && !ex_i.an) |-> !(kill_if_o || kill_id_o || kill_of_o));

    assert_no_branch_no_kill_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !resolve |-> !(kill_if_o || kill_id_o || kill_of_o || redirect_o));

endmodule

// File: rtl/branch_slot_ctrl.sv
module branch_slot_ctrl
    import branch_slot_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  fetch_stall_i,
    input  logic                  id_branch_i,
    input  logic                  id_annul_i,
    input  logic                  ex_taken_i,
    input  logic [ADDR_W-1:0]     ex_target_i,
    output logic [ADDR_W-1:0]     fetch_pc_o,
    output logic                  kill_if_o,
    output logic                  kill_id_o,
    output logic                  kill_of_o,
    output logic [NUM_STAGES-1:0] stage_valid_o
);

    stage_tag_t id_tag, of_tag, ex_tag;
    logic       if_v;
    logic       redirect;
    logic       k_if, k_id, k_of;

    bsc_stage_track u_track (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .stall_i       (fetch_stall_i),
        .id_branch_i   (id_branch_i),
        .id_annul_i    (id_annul_i),
        .kill_if_i     (k_if),
        .kill_id_i     (k_id),
        .kill_of_i     (k_of),
        .id_o          (id_tag),
        .of_o          (of_tag),
        .ex_o          (ex_tag),
        .if_v_o        (if_v),
        .stage_valid_o (stage_valid_o)
    );

    bsc_squash u_squash (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ex_i       (ex_tag),
        .of_i       (of_tag),
        .id_i       (id_tag),
        .if_v_i     (if_v),
        .taken_i    (ex_taken_i),
        .redirect_o (redirect),
        .kill_if_o  (k_if),
        .kill_id_o  (k_id),
        .kill_of_o  (k_of)
    );

    bsc_pc_seq #(
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR_BYTES),
        .RESET_PC    (RESET_PC)
    ) u_pc (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .stall_i      (fetch_stall_i),
        .fetch_live_i (if_v),
        .redirect_i   (redirect),
        .target_i     (ex_target_i),
        .pc_o         (fetch_pc_o)
    );

    assign kill_if_o = k_if;
    assign kill_id_o = k_id;
    assign kill_of_o = k_of;

    assert_slot_survives_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redirect && of_tag.v && of_tag.slot) |=> stage_valid_o[STG_EX]);

    assert_taken_kills_fetch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redirect && !fetch_stall_i) |=> !stage_valid_o[STG_ID]);

endmodule

// File: tb/branch_slot_ctrl_test.sv
`timescale 1ns/1ps
module branch_slot_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall, id_br, id_an, ex_tk;
    logic [31:0] ex_tgt;
    logic [31:0] pc;
    logic        k_if, k_id, k_of;
    logic [4:0]  sv;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    branch_slot_ctrl uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .fetch_stall_i (stall),
        .id_branch_i   (id_br),
        .id_annul_i    (id_an),
        .ex_taken_i    (ex_tk),
        .ex_target_i   (ex_tgt),
        .fetch_pc_o    (pc),
        .kill_if_o     (k_if),
        .kill_id_o     (k_id),
        .kill_of_o     (k_of),
        .stage_valid_o (sv)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // reset, release, and advance to the state after edge 3:
    // IF=8, ID=4, OF=0 valid
    task automatic restart();
        rst_n = 1'b0; stall = 0; id_br = 0; id_an = 0; ex_tk = 0; ex_tgt = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (3) tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; stall = 0; id_br = 0; id_an = 0; ex_tk = 0; ex_tgt = '0;
        repeat (3) tick();
        chk("R1", "pc in reset", pc, 32'h0);
        chk("R1", "valid in reset", {27'd0, sv}, 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1", "pc edge1", pc, 32'h0);
        chk("R1", "valid edge1", {27'd0, sv}, 32'h01);
        tick();
        chk("R2", "pc edge2", pc, 32'h4);
        chk("R2", "valid edge2", {27'd0, sv}, 32'h03);
        tick();
        chk("R2", "pc edge3", pc, 32'h8);
        tick(); tick();
        chk("R2", "valid full", {27'd0, sv}, 32'h1f);
        chk("R2", "pc edge5", pc, 32'h10);
    endtask

    // branch at 0x4 flagged in ID, resolves between edges 5 and 6
    task automatic run_branch(input logic annul, input logic taken, output logic [2:0] kills,
                              output logic [31:0] pc6, output logic [4:0] sv6);
        restart();
        id_br = 1'b1; id_an = annul;
        tick();
        id_br = 1'b0; id_an = 1'b0;
        tick();
        ex_tk = taken; ex_tgt = 32'h100;
        #1;
        kills = {k_of, k_id, k_if};
        tick();
        ex_tk = 1'b0;
        pc6 = pc; sv6 = sv;
    endtask

    task automatic t_taken();
        logic [2:0] k; logic [31:0] p; logic [4:0] v;
        run_branch(1'b0, 1'b1, k, p, v);
        chk("R4", "kills {of,id,if}", {29'd0, k}, 32'h3);
        chk("R4", "pc target", p, 32'h100);
        chk("R5", "slot in EX", {27'd0, v}, 32'h19);
        chk("R11", "bubbles in OF/ID", {30'd0, v[2:1]}, 32'h0);
        tick();
        chk("R5", "slot reaches WB", {27'd0, sv}, 32'h13);
        chk("R2", "pc after target", pc, 32'h104);
    endtask

    task automatic t_fall();
        logic [2:0] k; logic [31:0] p; logic [4:0] v;
        run_branch(1'b0, 1'b0, k, p, v);
        chk("R3", "no kills", {29'd0, k}, 32'h0);
        chk("R3", "pc sequential", p, 32'h14);
        chk("R3", "all valid", {27'd0, v}, 32'h1f);
    endtask

    task automatic t_annul_fall();
        logic [2:0] k; logic [31:0] p; logic [4:0] v;
        run_branch(1'b1, 1'b0, k, p, v);
        chk("R6", "slot killed", {29'd0, k}, 32'h4);
        chk("R6", "pc sequential", p, 32'h14);
        chk("R11", "bubble in EX", {27'd0, v}, 32'h17);
    endtask

    task automatic t_annul_taken();
        logic [2:0] k; logic [31:0] p; logic [4:0] v;
        run_branch(1'b1, 1'b1, k, p, v);
        chk("R7", "kills {of,id,if}", {29'd0, k}, 32'h3);
        chk("R7", "pc target", p, 32'h100);
        chk("R7", "slot kept", {27'd0, v}, 32'h19);
    endtask

    task automatic t_ignore();
        restart();
        tick(); tick();
        ex_tk = 1'b1; ex_tgt = 32'h300;
        #1;
        chk("R10", "no kills", {29'd0, k_of, k_id, k_if}, 32'h0);
        tick();
        ex_tk = 1'b0;
        chk("R10", "pc sequential", pc, 32'h14);
        chk("R10", "all valid", {27'd0, sv}, 32'h1f);
    endtask

    task automatic t_stall();
        restart();
        stall = 1'b1;
        tick();
        chk("R8", "pc held", pc, 32'h8);
        chk("R8", "OF bubble", {27'd0, sv}, 32'h0b);
        stall = 1'b0;
        tick();
        chk("R8", "pc resumes", pc, 32'hc);
        chk("R8", "valid resumes", {27'd0, sv}, 32'h17);
    endtask

    task automatic t_stall_redirect();
        restart();
        id_br = 1'b1;
        tick();
        id_br = 1'b0;
        stall = 1'b1;
        tick();
        ex_tk = 1'b1; ex_tgt = 32'h200;
        #1;
        chk("R9", "kills {of,id,if}", {29'd0, k_of, k_id, k_if}, 32'h1);
        tick();
        ex_tk = 1'b0;
        chk("R9", "pc held", pc, 32'hc);
        chk("R9", "valid", {27'd0, sv}, 32'h12);
        tick();
        chk("R9", "pc still held", pc, 32'hc);
        stall = 1'b0;
        tick();
        chk("R9", "pc target", pc, 32'h200);
        chk("R9", "slot in OF", {27'd0, sv}, 32'h05);
        tick();
        chk("R5", "slot in EX", {27'd0, sv}, 32'h0b);
        chk("R2", "pc after target", pc, 32'h204);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; stall = 0; id_br = 0; id_an = 0; ex_tk = 0; ex_tgt = '0;
        @(negedge clk);
        t_reset();
        t_taken();
        t_fall();
        t_annul_fall();
        t_annul_taken();
        t_ignore();
        t_stall();
        t_stall_redirect();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule